// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the serial configuration port of a multi-channel data converter. A host talks to it over a four-wire serial link: a clock, a data input, a data output and a set of active-low chip selects. Each chip select addresses its own copy of a small register bank. Each copy sets the format, power-down, output drive strength and test-pattern controls for one group of converter channels. The register fields leave the block as static outputs that the rest of the design decodes.

Every transfer is one 16-bit frame. The first bit chooses write or read, seven address bits follow, and eight data bits close the frame. A write commits only when the chip selects return high after exactly sixteen clocks. A read leaves the register untouched and shifts its contents out on an open-drain style output during the last eight clocks. That output only ever pulls low and is released at every other time.

The serial inputs are brought into the system clock domain through a synchronizer and are oversampled. Serial clock edges are therefore detected as level changes of the synchronized clock, and the serial clock must run several times slower than the system clock.

Top module: `cfg_spi_slave`

## Requirements
- R1: A frame carries R/W first (1 = read, 0 = write), then address bits 6..0, then data bits 7..0, each MSB first and sampled on a rising serial clock edge. A write commits to the register once every chip select is high again after exactly 16 rising edges.
- R2: A frame that ends with fewer or more than 16 rising edges changes no register.
- R3: `sdo_pulldown` is 0 (line released) at all times except the eight readback bit slots of a read frame. This includes idle, the header of a read and the whole of a write frame.
- R4: In a read frame, the addressed register bit 7 is driven after the falling edge that follows the eighth rising edge. Each following bit, down to bit 0, is driven after the next falling edge. The line is pulled low for a 0 and released for a 1. A read modifies no register, and the data bits sent on the input are ignored.
- R5: Bank b is selected by `spi_cs_n[b]` low, and banks hold independent contents. If several chip selects are low at frame start, a write updates every selected bank and a read returns the lowest-numbered selected bank.
- R6: Address 01h is the format register: bit 7 duty-cycle-stabilizer off (`dcs_off`), bit 6 randomizer (`rand_en`), bit 5 two's complement (`twos_en`), bit 4 sleep (`sleep_en`), bits 3..0 per-channel nap (`nap`).
- R7: Address 02h bits 2..0 hold the output drive code (`drive_sel`), where code 0 is the default 3.5 mA level. Bits 7..3 are not stored and read as 0.
- R8: Address 03h bit 7 is test-pattern enable (`pat_en`), bit 6 is not stored and reads 0, and bits 5..0 are pattern bits 13..8. Address 04h holds pattern bits 7..0 (`pat_word`).
- R9: After reset every register and field output is 0, and the output line is released.
- R10: A write to address 00h with data bit 7 set clears every register of the selected bank; with bit 7 clear it does nothing. Address 00h and addresses above 04h read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_sdi | input | 1 | Serial data from host |
| spi_cs_n | input | NUM_BANKS | Active-low chip select, one per register bank |
| sdo_pulldown | output | 1 | 1 pulls the open-drain data line low, 0 releases it |
| dcs_off | output | NUM_BANKS | Duty-cycle stabilizer off, per bank |
| rand_en | output | NUM_BANKS | Output randomizer enable, per bank |
| twos_en | output | NUM_BANKS | Two's complement format, per bank |
| sleep_en | output | NUM_BANKS | Full sleep, per bank |
| nap | output | NUM_BANKS x 4 | Per-channel nap controls, per bank |
| drive_sel | output | NUM_BANKS x 3 | Output drive current code, per bank |
| pat_en | output | NUM_BANKS | Test pattern enable, per bank |
| pat_word | output | NUM_BANKS x 14 | Test pattern value, per bank |

## Verification
The bench builds the block with two banks and a two-stage synchronizer, and clocks the serial link at one twelfth of the system clock. With two chip selects it can cover the banks' independence, a broadcast write with both selects low, and the lowest-bank priority on readback. The twelve-cycle bit time leaves room to observe the three-cycle path from a falling serial edge to the output line. Short and long frames, the software clear and unmapped addresses are then checked at the field outputs and through readback.

// File: rtl/cfg_spi_pkg.sv
`timescale 1ns/1ps
package cfg_spi_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int PAT_W      = 14;
    localparam int DRIVE_W    = 3;
    localparam int NAP_W      = 4;

    // Register offsets: the bank decodes these, the host depends on them
    localparam logic [ADDR_W-1:0] REG_CTRL   = 7'h00;
    localparam logic [ADDR_W-1:0] REG_FMT    = 7'h01;
    localparam logic [ADDR_W-1:0] REG_DRIVE  = 7'h02;
    localparam logic [ADDR_W-1:0] REG_PAT_HI = 7'h03;
    localparam logic [ADDR_W-1:0] REG_PAT_LO = 7'h04;

    localparam int SWRST_BIT  = 7;
    localparam int PAT_EN_BIT = 7;

    typedef struct packed {
        logic             dcs_off;
        logic             rand_en;
        logic             twos_en;
        logic             sleep;
        logic [NAP_W-1:0] nap;
    } fmt_t;

    typedef struct packed {
        fmt_t               fmt;
        logic [DRIVE_W-1:0] drive;
        logic               pat_en;
        logic [PAT_W-1:0]   pat;
    } bank_regs_t;
endpackage

// File: rtl/cfg_spi_sync.sv
`timescale 1ns/1ps
module cfg_spi_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
`timescale 1ns/1ps
module cfg_spi_frame
    import cfg_spi_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic [NUM_BANKS-1:0] cs_n,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 frm_active,
    output logic [NUM_BANKS-1:0] sel_mask,
    output logic                 wr_stb,
    output logic [ADDR_W-1:0]    addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 sdo_pulldown
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(1 + ADDR_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic                 active;
        logic                 sck_prev;
        logic [NUM_BANKS-1:0] sel;
        logic [CNT_W-1:0]     cnt;
        logic                 rw;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    data;
        logic [DATA_W-1:0]    rd_sh;
        logic                 drv;
        logic                 bitv;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic any_sel, rise, fall;

    always_comb begin
        st_d    = st_q;
        wr_stb  = 1'b0;
        any_sel = ~&cs_n;
        rise    = st_q.active & sck & ~st_q.sck_prev;
        fall    = st_q.active & ~sck & st_q.sck_prev;
        st_d.sck_prev = sck;

        if (!st_q.active) begin
            if (any_sel) begin
                st_d.active = 1'b1;
                st_d.sel    = ~cs_n;
                st_d.cnt    = CNT_ZERO;
                st_d.rw     = 1'b0;
                st_d.drv    = 1'b0;
            end
        end else if (!any_sel) begin
            // frame closes: commit only a complete write frame
            st_d.active = 1'b0;
            st_d.drv    = 1'b0;
            wr_stb      = (st_q.cnt == CNT_FULL) & ~st_q.rw;
        end else begin
            if (rise) begin
                if (st_q.cnt == CNT_ZERO) begin
                    st_d.rw = sdi;
                end else if (st_q.cnt < CNT_HDR) begin
                    st_d.addr = {st_q.addr[ADDR_W-2:0], sdi};
                end else if (st_q.cnt < CNT_FULL) begin
                    st_d.data = {st_q.data[DATA_W-2:0], sdi};
                end
                if (st_q.cnt != CNT_OVER) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (fall && st_q.rw) begin
                if (st_q.cnt == CNT_HDR) begin
                    st_d.drv   = 1'b1;
                    st_d.bitv  = rd_data[DATA_W-1];
                    st_d.rd_sh = {rd_data[DATA_W-2:0], 1'b0};
                end else if (st_q.cnt > CNT_HDR && st_q.cnt < CNT_FULL) begin
                    st_d.bitv  = st_q.rd_sh[DATA_W-1];
                    st_d.rd_sh = {st_q.rd_sh[DATA_W-2:0], 1'b0};
                end else begin
                    st_d.drv   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frm_active   = st_q.active;
    assign sel_mask     = st_q.sel;
    assign addr         = st_q.addr;
    assign wr_data      = st_q.data;
    assign sdo_pulldown = st_q.drv & ~st_q.bitv;
endmodule

// File: rtl/cfg_spi_bank.sv
`timescale 1ns/1ps
module cfg_spi_bank
    import cfg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output bank_regs_t        regs
);
    localparam int HI_W = PAT_W - DATA_W;

    bank_regs_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            case (addr)
                REG_CTRL: begin
                    if (wr_data[SWRST_BIT]) bank_d = '0;
                end
                REG_FMT:    bank_d.fmt = wr_data;
                REG_DRIVE:  bank_d.drive = wr_data[DRIVE_W-1:0];
                REG_PAT_HI: begin
                    bank_d.pat_en             = wr_data[PAT_EN_BIT];
                    bank_d.pat[PAT_W-1:DATA_W] = wr_data[HI_W-1:0];
                end
                REG_PAT_LO: bank_d.pat[DATA_W-1:0] = wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            REG_FMT:    rd_data = bank_q.fmt;
            REG_DRIVE:  rd_data = {{(DATA_W-DRIVE_W){1'b0}}, bank_q.drive};
            REG_PAT_HI: rd_data = {bank_q.pat_en, {(DATA_W-1-HI_W){1'b0}},
                                   bank_q.pat[PAT_W-1:DATA_W]};
            REG_PAT_LO: rd_data = bank_q.pat[DATA_W-1:0];
            default:    rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign regs = bank_q;
endmodule

// File: rtl/cfg_spi_slave.sv
`timescale 1ns/1ps
module cfg_spi_slave
    import cfg_spi_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              spi_sck,
    input  logic                              spi_sdi,
    input  logic [NUM_BANKS-1:0]              spi_cs_n,
    output logic                              sdo_pulldown,
    output logic [NUM_BANKS-1:0]              dcs_off,
    output logic [NUM_BANKS-1:0]              rand_en,
    output logic [NUM_BANKS-1:0]              twos_en,
    output logic [NUM_BANKS-1:0]              sleep_en,
    output logic [NUM_BANKS-1:0][NAP_W-1:0]   nap,
    output logic [NUM_BANKS-1:0][DRIVE_W-1:0] drive_sel,
    output logic [NUM_BANKS-1:0]              pat_en,
    output logic [NUM_BANKS-1:0][PAT_W-1:0]   pat_word
);
    localparam int SYNC_W = NUM_BANKS + 2;

    logic [SYNC_W-1:0]              sync_q;
    logic                           s_sck, s_sdi;
    logic [NUM_BANKS-1:0]           s_cs_n;
    logic                           frm_active, wr_stb;
    logic [NUM_BANKS-1:0]           sel_mask;
    logic [ADDR_W-1:0]              wr_addr;
    logic [DATA_W-1:0]              wr_data, rd_data;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
    bank_regs_t                     bank_regs [NUM_BANKS];

    cfg_spi_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({{NUM_BANKS{1'b1}}, 2'b00})
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sdi, spi_sck}),
        .q     (sync_q)
    );

    assign s_sck  = sync_q[0];
    assign s_sdi  = sync_q[1];
    assign s_cs_n = sync_q[SYNC_W-1:2];

    cfg_spi_frame #(.NUM_BANKS(NUM_BANKS)) frame_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck          (s_sck),
        .sdi          (s_sdi),
        .cs_n         (s_cs_n),
        .rd_data      (rd_data),
        .frm_active   (frm_active),
        .sel_mask     (sel_mask),
        .wr_stb       (wr_stb),
        .addr         (wr_addr),
        .wr_data      (wr_data),
        .sdo_pulldown (sdo_pulldown)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        cfg_spi_bank bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_stb & sel_mask[g]),
            .addr    (wr_addr),
            .wr_data (wr_data),
            .rd_data (bank_rd[g]),
            .regs    (bank_regs[g])
        );
        assign dcs_off[g]   = bank_regs[g].fmt.dcs_off;
        assign rand_en[g]   = bank_regs[g].fmt.rand_en;
        assign twos_en[g]   = bank_regs[g].fmt.twos_en;
        assign sleep_en[g]  = bank_regs[g].fmt.sleep;
        assign nap[g]       = bank_regs[g].fmt.nap;
        assign drive_sel[g] = bank_regs[g].drive;
        assign pat_en[g]    = bank_regs[g].pat_en;
        assign pat_word[g]  = bank_regs[g].pat;
    end

    // lowest-numbered selected bank answers a readback
    always_comb begin
        rd_data = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (sel_mask[b]) rd_data = bank_rd[b];
        end
    end
endmodule

// File: rtl/cfg_spi_slave_chk.sv
`timescale 1ns/1ps
module cfg_spi_slave_chk
    import cfg_spi_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              sdo_pulldown,
    input logic                              frm_active,
    input logic                              wr_stb,
    input logic [NUM_BANKS-1:0]              sel_mask,
    input logic [ADDR_W-1:0]                 wr_addr,
    input logic [DATA_W-1:0]                 wr_data,
    input logic [NUM_BANKS-1:0]              dcs_off,
    input logic [NUM_BANKS-1:0]              rand_en,
    input logic [NUM_BANKS-1:0]              twos_en,
    input logic [NUM_BANKS-1:0]              sleep_en,
    input logic [NUM_BANKS-1:0][NAP_W-1:0]   nap,
    input logic [NUM_BANKS-1:0][DRIVE_W-1:0] drive_sel,
    input logic [NUM_BANKS-1:0]              pat_en,
    input logic [NUM_BANKS-1:0][PAT_W-1:0]   pat_word
);
    localparam int FIELD_W = NUM_BANKS * (4 + NAP_W + DRIVE_W + 1 + PAT_W);
    logic [FIELD_W-1:0] all_fields;
    assign all_fields = {dcs_off, rand_en, twos_en, sleep_en, nap, drive_sel, pat_en, pat_word};

    AST_SDO_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_active |-> !sdo_pulldown);                                    // R3

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(all_fields));                                  // R2

    AST_WRITE_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (sel_mask != '0));                                      // R5

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && sel_mask[b] && wr_addr == REG_CTRL && wr_data[SWRST_BIT])
            |=> (!dcs_off[b] && !rand_en[b] && !twos_en[b] && !sleep_en[b] &&
                 nap[b] == '0 && drive_sel[b] == '0 && !pat_en[b] &&
                 pat_word[b] == '0));                                      // R10
    end
endmodule

bind cfg_spi_slave cfg_spi_slave_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sdo_pulldown (sdo_pulldown),
    .frm_active   (frm_active),
    .wr_stb       (wr_stb),
    .sel_mask     (sel_mask),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .dcs_off      (dcs_off),
    .rand_en      (rand_en),
    .twos_en      (twos_en),
    .sleep_en     (sleep_en),
    .nap          (nap),
    .drive_sel    (drive_sel),
    .pat_en       (pat_en),
    .pat_word     (pat_word)
);

// File: tb/cfg_spi_slave_tb_top.sv
`timescale 1ns/1ps
module cfg_spi_slave_tb_top;
    localparam int NB   = 2;
    localparam int HALF = 6;

    typedef struct packed {
        logic [1:0] mask;
        logic       rd;
        logic [6:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    // word sent = {rd, addr, data}; exp checked for reads only
    localparam vec_t VECS [19] = '{
        '{2'b10, 1'b1, 7'h04, 8'h00, 8'h00},  // R9 bank1 pattern low after reset
        '{2'b01, 1'b0, 7'h01, 8'hA5, 8'h00},  // R6 write bank0 format
        '{2'b10, 1'b0, 7'h01, 8'h3C, 8'h00},  // R5 write bank1 format
        '{2'b01, 1'b1, 7'h01, 8'h00, 8'hA5},  // R4 read bank0 format
        '{2'b10, 1'b1, 7'h01, 8'h00, 8'h3C},  // R5 bank1 independent
        '{2'b01, 1'b0, 7'h02, 8'hFE, 8'h00},  // R7 drive code write
        '{2'b01, 1'b1, 7'h02, 8'h00, 8'h06},  // R7 upper bits not stored
        '{2'b01, 1'b0, 7'h03, 8'hFF, 8'h00},  // R8 pattern high write
        '{2'b01, 1'b1, 7'h03, 8'h00, 8'hBF},  // R8 bit6 reads 0
        '{2'b01, 1'b0, 7'h04, 8'h5A, 8'h00},  // R8 pattern low write
        '{2'b01, 1'b1, 7'h04, 8'hFF, 8'h5A},  // R4 read ignores data bits
        '{2'b01, 1'b1, 7'h04, 8'h00, 8'h5A},  // R4 read did not modify
        '{2'b01, 1'b0, 7'h07, 8'h77, 8'h00},  // R10 unmapped write
        '{2'b01, 1'b1, 7'h07, 8'h00, 8'h00},  // R10 unmapped reads 0
        '{2'b01, 1'b1, 7'h00, 8'h00, 8'h00},  // R10 address 00h reads 0
        '{2'b11, 1'b0, 7'h02, 8'h05, 8'h00},  // R5 broadcast write
        '{2'b10, 1'b1, 7'h02, 8'h00, 8'h05},  // R5 bank1 got broadcast
        '{2'b11, 1'b1, 7'h01, 8'h00, 8'hA5},  // R5 lowest bank answers
        '{2'b01, 1'b1, 7'h02, 8'h00, 8'h05}   // R1 bank0 got broadcast
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_sdi = 1'b0;
    logic [NB-1:0] spi_cs_n = '1;
    logic sdo_pulldown;
    logic [NB-1:0] dcs_off, rand_en, twos_en, sleep_en, pat_en;
    logic [NB-1:0][3:0]  nap;
    logic [NB-1:0][2:0]  drive_sel;
    logic [NB-1:0][13:0] pat_word;

    int  n_chk = 0;
    int  n_err = 0;
    int  rel_viol = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    cfg_spi_slave #(.NUM_BANKS(NB), .SYNC_STAGES(2)) dut_i (
        .clk (clk), .rst_n (rst_n), .spi_sck (spi_sck), .spi_sdi (spi_sdi),
        .spi_cs_n (spi_cs_n), .sdo_pulldown (sdo_pulldown),
        .dcs_off (dcs_off), .rand_en (rand_en), .twos_en (twos_en),
        .sleep_en (sleep_en), .nap (nap), .drive_sel (drive_sel),
        .pat_en (pat_en), .pat_word (pat_word)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame of nbits clocks; a 16-bit read collects the returned byte.
    task automatic xfer(input logic [1:0] mask, input logic [15:0] word,
                        input int nbits, output logic [7:0] rd);
        rd = '0;
        @(negedge clk);
        spi_cs_n = ~mask;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            spi_sdi = (i < 16) ? word[15-i] : 1'b0;
            wait_clk(HALF);
            if (word[15] && nbits == 16 && i >= 8) begin
                rd = {rd[6:0], ~sdo_pulldown};
            end else if (sdo_pulldown) begin
                rel_viol++;
            end
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
        wait_clk(HALF);
        if (sdo_pulldown) rel_viol++;
        spi_cs_n = '1;
        wait_clk(HALF);
        if (sdo_pulldown) rel_viol++;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        wait_clk(5);
        // R9: reset state
        check("R9 fields zero during reset",
              {dcs_off, rand_en, twos_en, sleep_en, nap, pat_en, drive_sel}, '0);
        rst_n = 1'b1;
        wait_clk(5);
        check("R9 pattern zero after reset", pat_word, '0);
        check("R9 line released after reset", sdo_pulldown, 1'b0);

        // vector table
        for (int v = 0; v < 19; v++) begin
            xfer(VECS[v].mask, {VECS[v].rd, VECS[v].addr, VECS[v].data}, 16, rd);
            if (VECS[v].rd) begin
                check($sformatf("R4 readback vector %0d", v), rd, VECS[v].exp);
            end
        end

        // R6 / R7 / R8 / R5 field outputs
        check("R6 bank0 format fields", {dcs_off[0], rand_en[0], twos_en[0], sleep_en[0], nap[0]}, 8'hA5);
        check("R6 bank1 format fields", {dcs_off[1], rand_en[1], twos_en[1], sleep_en[1], nap[1]}, 8'h3C);
        check("R7 drive codes both banks", {drive_sel[1], drive_sel[0]}, 6'o55);
        check("R8 bank0 pattern enable", pat_en, 2'b01);
        check("R8 bank0 pattern value", pat_word[0], 14'h3F5A);
        check("R5 bank1 pattern untouched", pat_word[1], 14'h0000);

        // R2: short frame discarded
        xfer(2'b01, {1'b0, 7'h01, 8'h00}, 10, rd);
        check("R2 short frame no write", {dcs_off[0], rand_en[0], twos_en[0], sleep_en[0], nap[0]}, 8'hA5);
        // R2: long frame discarded
        xfer(2'b01, {1'b0, 7'h01, 8'h00}, 17, rd);
        check("R2 long frame no write", {dcs_off[0], rand_en[0], twos_en[0], sleep_en[0], nap[0]}, 8'hA5);
        xfer(2'b01, {1'b1, 7'h01, 8'h00}, 16, rd);
        check("R2 format readback after bad frames", rd, 8'hA5);

        // R10: control write without clear bit does nothing
        xfer(2'b01, {1'b0, 7'h00, 8'h7F}, 16, rd);
        check("R10 no clear without bit7", pat_word[0], 14'h3F5A);
        // R10: software clear of bank1 only
        xfer(2'b10, {1'b0, 7'h00, 8'h80}, 16, rd);
        check("R10 bank1 cleared",
              {dcs_off[1], rand_en[1], twos_en[1], sleep_en[1], nap[1], drive_sel[1], pat_en[1]}, '0);
        check("R10 bank0 kept", {drive_sel[0], pat_en[0]}, 4'b1011);
        xfer(2'b10, {1'b1, 7'h02, 8'h00}, 16, rd);
        check("R10 bank1 drive reads 0 after clear", rd, 8'h00);

        // R1: write committed and visible after exactly 16 clocks
        xfer(2'b10, {1'b0, 7'h04, 8'hC3}, 16, rd);
        check("R1 complete write committed", pat_word[1], 14'h00C3);

        // R3: line released outside readback slots across all frames
        check("R3 release violations", rel_viol, 0);
        check("R3 line released at end", sdo_pulldown, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule